// File: doc/BRIEF.md
# Rename Checkpoint Slot Allocator

This block hands out rename-table checkpoint slots to a superscalar front end. A slot is taken once per fetched instruction group and only when that group holds at least one control-flow instruction: a conditional branch, a call or a return. A group with several such instructions still takes only one slot. The block returns the slot index so that rename can store it with the group. When that group retires carrying the same index, the block releases the slot.

Slots are handed out and released in circular order. On a mispredict the block reports, one cycle later, the slot that the rename table must be rolled back to, together with the group tag that owns it. In the same update it releases every slot younger than that one, so the next allocation reuses the slot just after the restored one. When the pool is exhausted, or a mispredict is being processed, a group that needs a slot is held with a stall output. The rename-table storage and the backout of single instructions sit outside this block.

Top module: `ckpt_alloc_top`

## Requirements
- R1: After reset all 32 slots are free: `freeCount` is 32, `allocIdx` is 0, `allocStall` and `restoreValid` are low.
- R2: A requesting group in which any lane carries a control-flow kind is granted exactly one slot in the same cycle, at index `allocIdx`, and `freeCount` drops by one after the clock edge. This holds even when several lanes are control-flow. Lane kind codes are 2 bits per lane, lane n at bits [2n+1:2n]: 0 none, 1 conditional branch, 2 call, 3 return.
- R3: A requesting group whose lanes are all kind 0 gets no grant and no stall, and `freeCount` is unchanged.
- R4: A group whose only control-flow lane is a call or a return is granted a slot just as a branch group is.
- R5: When `freeCount` is 0, a group that needs a slot sees `allocStall` high and no grant, until a slot is released.
- R6: A retire with the checkpoint flag set frees a slot only when its index equals the oldest live slot and its tag equals the tag recorded at allocation. Any other retire, including one with the flag clear, leaves `freeCount` unchanged.
- R7: An allocation and a release in the same cycle leave `freeCount` unchanged.
- R8: A mispredict naming live slot m raises `restoreValid` in the next cycle with `restoreIdx` = m and `restoreOwner` = the tag recorded for m. Every slot younger than m is freed, so `freeCount` becomes 32 minus (distance from oldest slot to m, plus one), and the next grant uses index m+1.
- R9: In a cycle with a mispredict no slot is granted; a group that needs one sees `allocStall`.
- R10: Indices wrap: the slot after index 31 is index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | A group is presented to rename this cycle |
| allocKinds | input | 8 | Per-lane control-flow kind, 2 bits per lane |
| allocTag | input | 6 | Tag of the presented group |
| allocGrant | output | 1 | A slot is taken for the group this cycle |
| allocIdx | output | 5 | Index of the next slot to be handed out |
| allocStall | output | 1 | Group needs a slot but none can be given |
| retireValid | input | 1 | A group retires this cycle |
| retireHasCkpt | input | 1 | The retiring group recorded a checkpoint index |
| retireIdx | input | 5 | Checkpoint index recorded with the retiring group |
| retireTag | input | 6 | Tag of the retiring group |
| mispValid | input | 1 | A mispredict resolves this cycle |
| mispIdx | input | 5 | Checkpoint index of the mispredicting group |
| restoreValid | output | 1 | Restore request, one cycle after a mispredict |
| restoreIdx | output | 5 | Slot the rename table rolls back to |
| restoreOwner | output | 6 | Tag of the group owning the restored slot |
| freeCount | output | 6 | Number of free slots |

## Verification
On every cycle the assertions check that a granted slot was free, that a released slot was live, that a mispredict names a live slot and is echoed on the restore port one cycle later, that a simultaneous grant and release keep the count steady, and that the live-slot map and the free count always agree. Only the bench scenarios can show the exact index order, the wrap from 31 to 0, and the rejection of retires with the wrong index or tag. They also show the count after a rollback from a full pool and the stall when the pool is empty or a mispredict is in progress.

// File: rtl/ckpt_alloc_pkg.sv
package ckpt_alloc_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_CALL = 2'd2,
    KIND_RETURN = 2'd3
  } lane_kind_e;

  typedef struct packed {
    logic doAlloc;
    logic doFree;
    logic doRestore;
  } ckpt_strobe_t;
endpackage

// File: rtl/ckpt_need_detect.sv
module ckpt_need_detect #(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W*2-1:0] kinds,
  output logic                 needCkpt
);
  import ckpt_alloc_pkg::*;
  logic [GROUP_W-1:0] laneFlow;

  // Any lane that is a branch, call or return makes the group need one slot.
  for (genvar g = 0; g < GROUP_W; g++) begin : g_lane
    lane_kind_e laneKind;
    assign laneKind    = lane_kind_e'(kinds[2*g +: 2]);
    assign laneFlow[g] = (laneKind != KIND_NONE);
  end

  assign needCkpt = |laneFlow;
endmodule

// File: rtl/ckpt_alloc_ctrl.sv
module ckpt_alloc_ctrl #(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         allocReq,
  input  logic                         needCkpt,
  input  logic                         retireValid,
  input  logic                         retireHasCkpt,
  input  logic [IDX_W-1:0]             retireIdx,
  input  logic                         retireOwnerOk,
  input  logic                         mispValid,
  input  logic [IDX_W-1:0]             mispIdx,
  output ckpt_alloc_pkg::ckpt_strobe_t strobe,
  output logic [IDX_W-1:0]             headPtr,
  output logic [IDX_W-1:0]             tailPtr,
  output logic                         allocStall,
  output logic [CNT_W-1:0]             freeCount
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SLOTS);

  logic [CNT_W-1:0] usedCnt;
  logic [CNT_W-1:0] usedNext;
  logic [IDX_W-1:0] mispDist;
  logic             poolFull;

  assign poolFull = (usedCnt == FULL);
  assign mispDist = mispIdx - tailPtr;

  always_comb begin
    strobe.doRestore = mispValid;
    strobe.doAlloc   = allocReq && needCkpt && !poolFull && !mispValid;
    strobe.doFree    = retireValid && retireHasCkpt && (usedCnt != '0)
                       && (retireIdx == tailPtr) && retireOwnerOk;
  end

  assign allocStall = allocReq && needCkpt && (poolFull || mispValid);
  assign freeCount  = FULL - usedCnt;

  always_comb begin
    if (strobe.doRestore) usedNext = CNT_W'(mispDist) + CNT_W'(1);
    else                  usedNext = usedCnt + CNT_W'(strobe.doAlloc);
    usedNext = usedNext - CNT_W'(strobe.doFree);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedCnt <= '0;
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      usedCnt <= usedNext;
      if (strobe.doRestore)    headPtr <= mispIdx + IDX_W'(1);
      else if (strobe.doAlloc) headPtr <= headPtr + IDX_W'(1);
      if (strobe.doFree)       tailPtr <= tailPtr + IDX_W'(1);
    end
  end

  // R7: a grant and a release in one cycle keep the occupancy
  a_r7_count_steady: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doAlloc && strobe.doFree) |=> (freeCount == $past(freeCount)));

  // R2: a lone grant lowers the free count by exactly one
  a_r2_grant_takes_one: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doAlloc && !strobe.doFree) |=> (freeCount == $past(freeCount) - CNT_W'(1)));

  // R5: nothing is granted while the pool is empty
  a_r5_empty_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    (freeCount == '0) |-> !strobe.doAlloc);
endmodule

// File: rtl/ckpt_alloc_dpath.sv
module ckpt_alloc_dpath #(
  parameter int NUM_SLOTS = 32,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ckpt_alloc_pkg::ckpt_strobe_t strobe,
  input  logic [IDX_W-1:0]             headPtr,
  input  logic [IDX_W-1:0]             tailPtr,
  input  logic [TAG_W-1:0]             allocTag,
  input  logic [IDX_W-1:0]             retireIdx,
  input  logic [TAG_W-1:0]             retireTag,
  input  logic [IDX_W-1:0]             mispIdx,
  output logic                         retireOwnerOk,
  output logic [NUM_SLOTS-1:0]         slotLive,
  output logic                         restoreValid,
  output logic [IDX_W-1:0]             restoreIdx,
  output logic [TAG_W-1:0]             restoreOwner
);
  logic [TAG_W-1:0]     ownerTag [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] youngerMask;
  logic [IDX_W-1:0]     mispDist;

  assign mispDist      = mispIdx - tailPtr;
  assign retireOwnerOk = slotLive[retireIdx] && (ownerTag[retireIdx] == retireTag);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [IDX_W-1:0] slotDist;
    assign slotDist       = IDX_W'(s) - tailPtr;
    assign youngerMask[s] = (slotDist > mispDist);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotLive[s] <= 1'b0;
        ownerTag[s] <= '0;
      end else begin
        if (strobe.doAlloc && (headPtr == IDX_W'(s))) begin
          slotLive[s] <= 1'b1;
          ownerTag[s] <= allocTag;
        end else if ((strobe.doFree && (tailPtr == IDX_W'(s)))
                     || (strobe.doRestore && youngerMask[s])) begin
          slotLive[s] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restoreValid <= 1'b0;
      restoreIdx   <= '0;
      restoreOwner <= '0;
    end else begin
      restoreValid <= strobe.doRestore;
      if (strobe.doRestore) begin
        restoreIdx   <= mispIdx;
        restoreOwner <= ownerTag[mispIdx];
      end
    end
  end

  // R2: the slot handed out is not already held by a group
  a_r2_alloc_slot_free: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAlloc |-> !slotLive[headPtr]);

  // R6: only a live slot is ever released
  a_r6_free_live_slot: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doFree |-> slotLive[tailPtr]);

  // R8: a mispredict targets a live slot and is echoed on the restore port
  a_r8_misp_target_live: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRestore |-> slotLive[mispIdx]);
  a_r8_restore_echo: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRestore |=> (restoreValid && restoreIdx == $past(mispIdx)));
endmodule

// File: rtl/ckpt_alloc_top.sv
module ckpt_alloc_top #(
  parameter int NUM_SLOTS = 32,
  parameter int GROUP_W = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocReq,
  input  logic [GROUP_W*2-1:0] allocKinds,
  input  logic [TAG_W-1:0]     allocTag,
  output logic                 allocGrant,
  output logic [IDX_W-1:0]     allocIdx,
  output logic                 allocStall,
  input  logic                 retireValid,
  input  logic                 retireHasCkpt,
  input  logic [IDX_W-1:0]     retireIdx,
  input  logic [TAG_W-1:0]     retireTag,
  input  logic                 mispValid,
  input  logic [IDX_W-1:0]     mispIdx,
  output logic                 restoreValid,
  output logic [IDX_W-1:0]     restoreIdx,
  output logic [TAG_W-1:0]     restoreOwner,
  output logic [CNT_W-1:0]     freeCount
);
  ckpt_alloc_pkg::ckpt_strobe_t strobe;
  logic                 needCkpt;
  logic                 retireOwnerOk;
  logic [IDX_W-1:0]     headPtr;
  logic [IDX_W-1:0]     tailPtr;
  logic [NUM_SLOTS-1:0] slotLive;

  ckpt_need_detect #(.GROUP_W(GROUP_W)) need_i (
    .kinds(allocKinds), .needCkpt(needCkpt)
  );

  ckpt_alloc_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .needCkpt(needCkpt),
    .retireValid(retireValid), .retireHasCkpt(retireHasCkpt),
    .retireIdx(retireIdx), .retireOwnerOk(retireOwnerOk),
    .mispValid(mispValid), .mispIdx(mispIdx), .strobe(strobe),
    .headPtr(headPtr), .tailPtr(tailPtr), .allocStall(allocStall),
    .freeCount(freeCount)
  );

  ckpt_alloc_dpath #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headPtr(headPtr),
    .tailPtr(tailPtr), .allocTag(allocTag), .retireIdx(retireIdx),
    .retireTag(retireTag), .mispIdx(mispIdx), .retireOwnerOk(retireOwnerOk),
    .slotLive(slotLive), .restoreValid(restoreValid),
    .restoreIdx(restoreIdx), .restoreOwner(restoreOwner)
  );

  assign allocGrant = strobe.doAlloc;
  assign allocIdx   = headPtr;

  // R10: the live-slot map held by the datapath matches the control's count
  a_r10_map_matches_count: assert property (@(posedge clk) disable iff (!rstN)
    (CNT_W'($countones(slotLive)) + freeCount) == CNT_W'(NUM_SLOTS));
endmodule

// File: tb/ckpt_alloc_top_tb_top.sv
module ckpt_alloc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       aReq;
    logic [7:0] kinds;
    logic [5:0] tag;
    logic       rV;
    logic       rHas;
    logic [4:0] rIdx;
    logic [5:0] rTag;
    logic       mV;
    logic [4:0] mIdx;
    logic       eGrant;
    logic [4:0] eIdx;
    logic       eStall;
    logic [5:0] eFree;
    logic       eRv;
    logic [4:0] eRIdx;
    logic [5:0] eROwn;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R2 single branch
    '{1'b1, 8'h01, 6'd5,  1'b0, 1'b0, 5'd0, 6'd0, 1'b0, 5'd0, 1'b1, 5'd0, 1'b0, 6'd31, 1'b0, 5'd0, 6'd0},
    // R2 two branches, one slot
    '{1'b1, 8'h05, 6'd6,  1'b0, 1'b0, 5'd0, 6'd0, 1'b0, 5'd0, 1'b1, 5'd1, 1'b0, 6'd30, 1'b0, 5'd0, 6'd0},
    // R3 no control flow
    '{1'b1, 8'h00, 6'd7,  1'b0, 1'b0, 5'd0, 6'd0, 1'b0, 5'd0, 1'b0, 5'd2, 1'b0, 6'd30, 1'b0, 5'd0, 6'd0},
    // R4 call on lane 3
    '{1'b1, 8'h80, 6'd8,  1'b0, 1'b0, 5'd0, 6'd0, 1'b0, 5'd0, 1'b1, 5'd2, 1'b0, 6'd29, 1'b0, 5'd0, 6'd0},
    // R4 return on lane 1
    '{1'b1, 8'h0C, 6'd9,  1'b0, 1'b0, 5'd0, 6'd0, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0, 6'd28, 1'b0, 5'd0, 6'd0},
    // R6 retire of a non-oldest slot ignored
    '{1'b0, 8'h00, 6'd0,  1'b1, 1'b1, 5'd1, 6'd6, 1'b0, 5'd0, 1'b0, 5'd4, 1'b0, 6'd28, 1'b0, 5'd0, 6'd0},
    // R6 wrong tag ignored
    '{1'b0, 8'h00, 6'd0,  1'b1, 1'b1, 5'd0, 6'd9, 1'b0, 5'd0, 1'b0, 5'd4, 1'b0, 6'd28, 1'b0, 5'd0, 6'd0},
    // R6 correct retire frees
    '{1'b0, 8'h00, 6'd0,  1'b1, 1'b1, 5'd0, 6'd5, 1'b0, 5'd0, 1'b0, 5'd4, 1'b0, 6'd29, 1'b0, 5'd0, 6'd0},
    // R6 flag clear ignored
    '{1'b0, 8'h00, 6'd0,  1'b1, 1'b0, 5'd1, 6'd6, 1'b0, 5'd0, 1'b0, 5'd4, 1'b0, 6'd29, 1'b0, 5'd0, 6'd0},
    // R7 grant and release together
    '{1'b1, 8'h01, 6'd10, 1'b1, 1'b1, 5'd1, 6'd6, 1'b0, 5'd0, 1'b1, 5'd4, 1'b0, 6'd29, 1'b0, 5'd0, 6'd0},
    // R8 R9 mispredict on slot 3 with a pending group
    '{1'b1, 8'h01, 6'd11, 1'b0, 1'b0, 5'd0, 6'd0, 1'b1, 5'd3, 1'b0, 5'd5, 1'b1, 6'd30, 1'b1, 5'd3, 6'd9},
    // R8 next grant follows the restored slot
    '{1'b1, 8'h01, 6'd11, 1'b0, 1'b0, 5'd0, 6'd0, 1'b0, 5'd0, 1'b1, 5'd4, 1'b0, 6'd29, 1'b0, 5'd0, 6'd0}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       allocReq;
  logic [7:0] allocKinds;
  logic [5:0] allocTag;
  logic       allocGrant;
  logic [4:0] allocIdx;
  logic       allocStall;
  logic       retireValid;
  logic       retireHasCkpt;
  logic [4:0] retireIdx;
  logic [5:0] retireTag;
  logic       mispValid;
  logic [4:0] mispIdx;
  logic       restoreValid;
  logic [4:0] restoreIdx;
  logic [5:0] restoreOwner;
  logic [5:0] freeCount;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckpt_alloc_top dut_i (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocKinds(allocKinds),
    .allocTag(allocTag), .allocGrant(allocGrant), .allocIdx(allocIdx),
    .allocStall(allocStall), .retireValid(retireValid),
    .retireHasCkpt(retireHasCkpt), .retireIdx(retireIdx), .retireTag(retireTag),
    .mispValid(mispValid), .mispIdx(mispIdx), .restoreValid(restoreValid),
    .restoreIdx(restoreIdx), .restoreOwner(restoreOwner), .freeCount(freeCount)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    allocReq = 1'b0; allocKinds = '0; allocTag = '0;
    retireValid = 1'b0; retireHasCkpt = 1'b0; retireIdx = '0; retireTag = '0;
    mispValid = 1'b0; mispIdx = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    idle();
    rstN = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive at the falling edge, sample combinational outputs before the rising edge,
  // registered outputs just after it
  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rstN = 1'b0;
    idle();
    doReset();
    #1;
    check("R1", "freeCount", freeCount, 32);
    check("R1", "allocIdx", allocIdx, 0);
    check("R1", "allocStall", allocStall, 0);
    check("R1", "restoreValid", restoreValid, 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      allocReq = VECS[v].aReq; allocKinds = VECS[v].kinds; allocTag = VECS[v].tag;
      retireValid = VECS[v].rV; retireHasCkpt = VECS[v].rHas;
      retireIdx = VECS[v].rIdx; retireTag = VECS[v].rTag;
      mispValid = VECS[v].mV; mispIdx = VECS[v].mIdx;
      #1;
      check("R2", $sformatf("vec%0d grant", v), allocGrant, VECS[v].eGrant);
      check("R2", $sformatf("vec%0d idx", v), allocIdx, VECS[v].eIdx);
      check("R9", $sformatf("vec%0d stall", v), allocStall, VECS[v].eStall);
      stepEdge();
      check("R7", $sformatf("vec%0d freeCount", v), freeCount, VECS[v].eFree);
      check("R8", $sformatf("vec%0d restoreValid", v), restoreValid, VECS[v].eRv);
      if (VECS[v].eRv) begin
        check("R8", $sformatf("vec%0d restoreIdx", v), restoreIdx, VECS[v].eRIdx);
        check("R8", $sformatf("vec%0d restoreOwner", v), restoreOwner, VECS[v].eROwn);
      end
    end

    // R5 / R10: fill the whole pool, then stall, free, wrap
    doReset();
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      idle();
      allocReq = 1'b1; allocKinds = 8'h01; allocTag = 6'(k);
      #1;
      check("R10", "fill grant", allocGrant, 1);
      check("R10", "fill idx", allocIdx, k);
      stepEdge();
    end
    check("R5", "freeCount full pool", freeCount, 0);
    @(negedge clk);
    idle();
    allocReq = 1'b1; allocKinds = 8'h40; allocTag = 6'd40;
    #1;
    check("R5", "stall when empty", allocStall, 1);
    check("R5", "no grant when empty", allocGrant, 0);
    stepEdge();
    check("R5", "count stays 0", freeCount, 0);
    @(negedge clk);
    idle();
    retireValid = 1'b1; retireHasCkpt = 1'b1; retireIdx = 5'd0; retireTag = 6'd0;
    stepEdge();
    check("R6", "release slot 0", freeCount, 1);
    @(negedge clk);
    idle();
    allocReq = 1'b1; allocKinds = 8'h01; allocTag = 6'd41;
    #1;
    check("R5", "stall cleared", allocStall, 0);
    check("R10", "wrap to index 0", allocIdx, 0);
    check("R10", "wrap grant", allocGrant, 1);
    stepEdge();
    check("R10", "full again", freeCount, 0);

    // R8 rollback from a full pool: oldest slot is 1, target 5 -> 5 live
    @(negedge clk);
    idle();
    mispValid = 1'b1; mispIdx = 5'd5;
    stepEdge();
    check("R8", "count after full rollback", freeCount, 27);
    check("R8", "restore idx full", restoreIdx, 5);
    check("R8", "restore owner full", restoreOwner, 5);
    @(negedge clk);
    idle();
    allocReq = 1'b1; allocKinds = 8'h03; allocTag = 6'd42;
    #1;
    check("R8", "grant after rollback", allocIdx, 6);
    stepEdge();
    check("R8", "restoreValid drops", restoreValid, 0);
    @(negedge clk);
    idle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule